// File: doc/BRIEF.md
# Paired Audio Sample Queues with Level Requests

This block sits between a processor-facing register port and an audio serializer. It has two 32-bit sample queues. The transmit queue is filled by the processor and drained by the serializer. The receive queue is filled by the serializer and drained by the processor.

Each queue reports its word count and drives a request line. The receive request compares the fill level against a 5-bit threshold plus one. The transmit request compares the free space against its own 5-bit threshold plus one. Four sticky error flags record pushes into a full queue and pops from an empty queue. Each flag drives an interrupt through its own enable. Each queue has a clear input that holds it empty while asserted. An optional byte swap reorders the bytes of every word that crosses the processor side.

Both read ports are show-ahead. The head word is on the data output whenever the queue is not empty, and a pop advances past it on the next clock.

Top module: `audio_fifo_pair`

## Requirements
- R1: After reset both counts are 0, `tx_req` is 1, `rx_req` is 0, and all error flags and interrupts are 0.
- R2: Each queue holds 32 words in first-in first-out order. The head word is shown on the read data output while the queue is not empty. The count rises by one on an accepted push and falls by one on an accepted pop.
- R3: `rx_req` is 1 exactly when `rx_count` is at least `rx_thresh` + 1.
- R4: `tx_req` is 1 exactly when 32 − `tx_count` is at least `tx_thresh` + 1.
- R5: A push into a full queue is dropped and the count stays 32. The drop sets that queue's overflow flag on the next clock: bit 0 for the receive queue, bit 2 for the transmit queue.
- R6: A pop from an empty queue reads zero data and the count stays 0. The pop sets that queue's underflow flag on the next clock: bit 1 for the receive queue, bit 3 for the transmit queue.
- R7: Error flags are sticky. A pulse on `err_wr` clears each flag whose `err_wdata` bit is 0 and leaves each flag whose bit is 1 unchanged. A new error event in the same cycle as a clear keeps that flag set.
- R8: `irq[i]` equals `err_flags[i]` AND `irq_en[i]` for each of the 4 bits.
- R9: While `tx_clr` or `rx_clr` is 1, the matching queue reads count 0 and zero data. Its pushes and pops are ignored and set no error flag.
- R10: When `swap_en` is 1, a word written by the processor is stored as {b2,b3,b0,b1}, where b3 is the most significant byte of the written word. A word read by the processor is presented in the same swapped order. The serializer side always sees words unswapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| swap_en | input | 1 | Byte swap on the processor side |
| tx_clr | input | 1 | Hold transmit queue cleared |
| rx_clr | input | 1 | Hold receive queue cleared |
| tx_thresh | input | 5 | Transmit free-space threshold |
| rx_thresh | input | 5 | Receive fill threshold |
| cpu_tx_push | input | 1 | Processor writes a transmit word |
| cpu_tx_data | input | 32 | Transmit word from processor |
| ser_tx_pop | input | 1 | Serializer takes a transmit word |
| ser_tx_data | output | 32 | Transmit head word to serializer |
| ser_rx_push | input | 1 | Serializer delivers a receive word |
| ser_rx_data | input | 32 | Receive word from serializer |
| cpu_rx_pop | input | 1 | Processor takes a receive word |
| cpu_rx_data | output | 32 | Receive head word to processor |
| tx_count | output | 6 | Transmit words stored |
| rx_count | output | 6 | Receive words stored |
| tx_req | output | 1 | Transmit free-space request |
| rx_req | output | 1 | Receive fill request |
| err_wr | input | 1 | Error flag clear strobe |
| err_wdata | input | 4 | Clear mask, 0 clears the flag |
| irq_en | input | 4 | Per-flag interrupt enables |
| err_flags | output | 4 | Sticky error flags |
| irq | output | 4 | Masked interrupts |

## Verification
The bench fills each queue one word at a time. At every level from 0 to 32 it sweeps the threshold through all 32 values. This tests every fill level and free-space level against every threshold, so an off-by-one in the plus-one comparison or a mix-up between fill and free space shows up.

Draining the queue checks the order of the distinct words pushed. Pushing one word past full and popping one past empty separates the four error bits. The bench then sweeps all 16 enable masks against the four raised flags.

Further cases cover:
- partial clear masks;
- a clear that arrives together with a new event;
- pushes and pops held off by the clear inputs;
- an asymmetric word that confirms the swap applies only on the processor side.

// File: rtl/afifo_pkg.sv
package afifo_pkg;
    localparam int ERR_W   = 4;
    localparam int ERR_RXO = 0;
    localparam int ERR_RXU = 1;
    localparam int ERR_TXO = 2;
    localparam int ERR_TXU = 3;

    typedef enum logic {
        LVL_FILL = 1'b0,
        LVL_FREE = 1'b1
    } lvl_mode_e;
endpackage

// File: rtl/afifo_swap.sv
module afifo_swap #(
    parameter int DW = 32
) (
    input  logic          en,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    localparam int HALVES = DW / 16;

    logic [DW-1:0] swapped;

    for (genvar h = 0; h < HALVES; h++) begin : g_half
        assign swapped[h*16 +: 8]     = din[h*16 + 8 +: 8];
        assign swapped[h*16 + 8 +: 8] = din[h*16 +: 8];
    end

    assign dout = en ? swapped : din;
endmodule

// File: rtl/afifo_queue.sv
module afifo_queue #(
    parameter int DW    = 32,
    parameter int DEPTH = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         push,
    input  logic [DW-1:0]                push_data,
    input  logic                         pop,
    output logic [DW-1:0]                pop_data,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         ovf_evt,
    output logic                         unf_evt
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } qstate_t;

    qstate_t st_d, st_q;
    logic [DW-1:0] mem [DEPTH];
    logic full, empty, push_ok, pop_ok;

    assign full    = (st_q.cnt == CW'(DEPTH));
    assign empty   = (st_q.cnt == '0);
    assign push_ok = push && !full && !clr;
    assign pop_ok  = pop && !empty && !clr;
    assign ovf_evt = push && full && !clr;
    assign unf_evt = pop && empty && !clr;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else begin
            if (push_ok)
                st_d.wp = (st_q.wp == AW'(DEPTH - 1)) ? '0 : st_q.wp + 1'b1;
            if (pop_ok)
                st_d.rp = (st_q.rp == AW'(DEPTH - 1)) ? '0 : st_q.rp + 1'b1;
            st_d.cnt = st_q.cnt + CW'(push_ok) - CW'(pop_ok);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[st_q.wp] <= push_data;
    end

    assign pop_data = empty ? '0 : mem[st_q.rp];
    assign count    = st_q.cnt;

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH)) else $error("count above depth"); // R2
    AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0)) else $error("clear did not empty queue"); // R9
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !clr) |=> (count == CW'(DEPTH))) else $error("push into full changed count"); // R5
endmodule

// File: rtl/afifo_thresh.sv
module afifo_thresh #(
    parameter int                  DEPTH = 32,
    parameter int                  TW    = 5,
    parameter afifo_pkg::lvl_mode_e MODE = afifo_pkg::LVL_FILL
) (
    input  logic [$clog2(DEPTH+1)-1:0] count,
    input  logic [TW-1:0]              thr,
    output logic                       req
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int XW = (CW > TW ? CW : TW) + 1;

    logic [XW-1:0] need;
    logic [XW-1:0] level;

    assign need = XW'(thr) + XW'(1);

    if (MODE == afifo_pkg::LVL_FREE) begin : g_free
        assign level = XW'(DEPTH) - XW'(count);
    end else begin : g_fill
        assign level = XW'(count);
    end

    assign req = (level >= need);
endmodule

// File: rtl/afifo_errs.sv
module afifo_errs #(
    parameter int NE = afifo_pkg::ERR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NE-1:0] evt,
    input  logic          wr,
    input  logic [NE-1:0] wdata,
    output logic [NE-1:0] flags
);
    logic [NE-1:0] flags_d, flags_q;

    always_comb begin
        flags_d = flags_q;
        if (wr) flags_d = flags_d & wdata;
        flags_d = flags_d | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags = flags_q;

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> ((flags_q & $past(flags_q)) == $past(flags_q))) else $error("flag dropped"); // R7
    AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((flags_q & $past(evt)) == $past(evt))) else $error("event not recorded"); // R5 R6
endmodule

// File: rtl/audio_fifo_pair.sv
module audio_fifo_pair #(
    parameter int DW    = 32,
    parameter int DEPTH = 32,
    parameter int TW    = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       swap_en,
    input  logic                       tx_clr,
    input  logic                       rx_clr,
    input  logic [TW-1:0]              tx_thresh,
    input  logic [TW-1:0]              rx_thresh,
    input  logic                       cpu_tx_push,
    input  logic [DW-1:0]              cpu_tx_data,
    input  logic                       ser_tx_pop,
    output logic [DW-1:0]              ser_tx_data,
    input  logic                       ser_rx_push,
    input  logic [DW-1:0]              ser_rx_data,
    input  logic                       cpu_rx_pop,
    output logic [DW-1:0]              cpu_rx_data,
    output logic [$clog2(DEPTH+1)-1:0] tx_count,
    output logic [$clog2(DEPTH+1)-1:0] rx_count,
    output logic                       tx_req,
    output logic                       rx_req,
    input  logic                       err_wr,
    input  logic [3:0]                 err_wdata,
    input  logic [3:0]                 irq_en,
    output logic [3:0]                 err_flags,
    output logic [3:0]                 irq
);
    import afifo_pkg::*;

    logic [DW-1:0] tx_wdata, rx_raw;
    logic tx_ovf, tx_unf, rx_ovf, rx_unf;
    logic [ERR_W-1:0] evt;

    afifo_swap #(.DW(DW)) u_tx_swap (
        .en(swap_en), .din(cpu_tx_data), .dout(tx_wdata)
    );

    afifo_queue #(.DW(DW), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .clr(tx_clr),
        .push(cpu_tx_push), .push_data(tx_wdata),
        .pop(ser_tx_pop), .pop_data(ser_tx_data),
        .count(tx_count), .ovf_evt(tx_ovf), .unf_evt(tx_unf)
    );

    afifo_queue #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clr(rx_clr),
        .push(ser_rx_push), .push_data(ser_rx_data),
        .pop(cpu_rx_pop), .pop_data(rx_raw),
        .count(rx_count), .ovf_evt(rx_ovf), .unf_evt(rx_unf)
    );

    afifo_swap #(.DW(DW)) u_rx_swap (
        .en(swap_en), .din(rx_raw), .dout(cpu_rx_data)
    );

    afifo_thresh #(.DEPTH(DEPTH), .TW(TW), .MODE(LVL_FREE)) u_tx_lvl (
        .count(tx_count), .thr(tx_thresh), .req(tx_req)
    );

    afifo_thresh #(.DEPTH(DEPTH), .TW(TW), .MODE(LVL_FILL)) u_rx_lvl (
        .count(rx_count), .thr(rx_thresh), .req(rx_req)
    );

    always_comb begin
        evt          = '0;
        evt[ERR_RXO] = rx_ovf;
        evt[ERR_RXU] = rx_unf;
        evt[ERR_TXO] = tx_ovf;
        evt[ERR_TXU] = tx_unf;
    end

    afifo_errs #(.NE(ERR_W)) u_errs (
        .clk(clk), .rst_n(rst_n), .evt(evt),
        .wr(err_wr), .wdata(err_wdata), .flags(err_flags)
    );

    assign irq = err_flags & irq_en;

    AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count == '0) |-> (cpu_rx_data == '0)) else $error("empty read not zero"); // R6
endmodule

// File: tb/audio_fifo_pair_bench.sv
`timescale 1ns/100ps
module audio_fifo_pair_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic swap_en = 0, tx_clr = 0, rx_clr = 0;
    logic [4:0] tx_thresh = 0, rx_thresh = 0;
    logic cpu_tx_push = 0, ser_tx_pop = 0, ser_rx_push = 0, cpu_rx_pop = 0;
    logic [31:0] cpu_tx_data = 0, ser_rx_data = 0;
    logic [31:0] ser_tx_data, cpu_rx_data;
    logic [5:0] tx_count, rx_count;
    logic tx_req, rx_req;
    logic err_wr = 0;
    logic [3:0] err_wdata = 0, irq_en = 0, err_flags, irq;

    int n_chk = 0;
    int n_bad = 0;
    logic [3:0] exp_err = 0;

    always #2 clk = ~clk;

    audio_fifo_pair u_audio_fifo_pair (
        .clk(clk), .rst_n(rst_n), .swap_en(swap_en), .tx_clr(tx_clr), .rx_clr(rx_clr),
        .tx_thresh(tx_thresh), .rx_thresh(rx_thresh),
        .cpu_tx_push(cpu_tx_push), .cpu_tx_data(cpu_tx_data),
        .ser_tx_pop(ser_tx_pop), .ser_tx_data(ser_tx_data),
        .ser_rx_push(ser_rx_push), .ser_rx_data(ser_rx_data),
        .cpu_rx_pop(cpu_rx_pop), .cpu_rx_data(cpu_rx_data),
        .tx_count(tx_count), .rx_count(rx_count), .tx_req(tx_req), .rx_req(rx_req),
        .err_wr(err_wr), .err_wdata(err_wdata), .irq_en(irq_en),
        .err_flags(err_flags), .irq(irq)
    );

    function automatic logic [31:0] val(int i);
        return 32'hA5A50000 + 32'(i) * 32'h00010101;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    task automatic sweep_rx(int lvl);
        for (int t = 0; t < 32; t++) begin
            rx_thresh = 5'(t);
            #0.5;
            chk("R3 rx_req", {31'd0, rx_req}, {31'd0, (lvl >= t + 1)});
        end
    endtask

    task automatic sweep_tx(int lvl);
        for (int t = 0; t < 32; t++) begin
            tx_thresh = 5'(t);
            #0.5;
            chk("R4 tx_req", {31'd0, tx_req}, {31'd0, ((32 - lvl) >= t + 1)});
        end
    endtask

    task automatic push_rx(logic [31:0] d);
        @(negedge clk);
        ser_rx_push = 1; ser_rx_data = d;
        @(negedge clk);
        ser_rx_push = 0;
    endtask

    task automatic push_tx(logic [31:0] d);
        @(negedge clk);
        cpu_tx_push = 1; cpu_tx_data = d;
        @(negedge clk);
        cpu_tx_push = 0;
    endtask

    task automatic pop_rx();
        @(negedge clk);
        cpu_rx_pop = 1;
        @(negedge clk);
        cpu_rx_pop = 0;
    endtask

    task automatic pop_tx();
        @(negedge clk);
        ser_tx_pop = 1;
        @(negedge clk);
        ser_tx_pop = 0;
    endtask

    task automatic err_write(logic [3:0] m);
        @(negedge clk);
        err_wr = 1; err_wdata = m;
        @(negedge clk);
        err_wr = 0;
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 rx_count", 32'(rx_count), 0);
        chk("R1 tx_count", 32'(tx_count), 0);
        chk("R1 tx_req", 32'(tx_req), 1);
        chk("R1 rx_req", 32'(rx_req), 0);
        chk("R1 err_flags", 32'(err_flags), 0);
        chk("R1 irq", 32'(irq), 0);

        // R3 receive fill sweep
        sweep_rx(0);
        for (int i = 0; i < 32; i++) begin
            push_rx(val(i));
            chk("R2 rx_count", 32'(rx_count), 32'(i + 1));
            sweep_rx(i + 1);
        end
        // R5 receive overflow
        push_rx(32'hDEADBEEF);
        exp_err[0] = 1;
        chk("R5 rx_count", 32'(rx_count), 32);
        chk("R5 err_flags", 32'(err_flags), 32'(exp_err));
        // R2 order, R5 dropped word absent
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            chk("R2 rx head", cpu_rx_data, val(i));
            pop_rx();
            chk("R2 rx_count", 32'(rx_count), 32'(31 - i));
        end
        // R6 receive underflow
        chk("R6 rx empty data", cpu_rx_data, 0);
        pop_rx();
        exp_err[1] = 1;
        chk("R6 rx_count", 32'(rx_count), 0);
        chk("R6 err_flags", 32'(err_flags), 32'(exp_err));

        // R4 transmit free-space sweep
        sweep_tx(0);
        for (int i = 0; i < 32; i++) begin
            push_tx(~val(i));
            chk("R2 tx_count", 32'(tx_count), 32'(i + 1));
            sweep_tx(i + 1);
        end
        push_tx(32'h0BADF00D);
        exp_err[2] = 1;
        chk("R5 tx_count", 32'(tx_count), 32);
        chk("R5 err_flags", 32'(err_flags), 32'(exp_err));
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            chk("R2 tx head", ser_tx_data, ~val(i));
            pop_tx();
        end
        chk("R6 tx empty data", ser_tx_data, 0);
        pop_tx();
        exp_err[3] = 1;
        chk("R6 tx_count", 32'(tx_count), 0);
        chk("R6 err_flags", 32'(err_flags), 32'(exp_err));

        // R8 all enable masks
        for (int m = 0; m < 16; m++) begin
            irq_en = 4'(m);
            #0.5;
            chk("R8 irq", 32'(irq), 32'(exp_err & 4'(m)));
        end

        // R7 selective clear and no-op write
        err_write(4'b1110);
        exp_err = 4'b1110;
        chk("R7 clear bit0", 32'(err_flags), 32'(exp_err));
        err_write(4'b1111);
        chk("R7 ones no effect", 32'(err_flags), 32'(exp_err));
        // R7 event wins over clear in same cycle
        @(negedge clk);
        cpu_rx_pop = 1; err_wr = 1; err_wdata = 4'b1101;
        @(negedge clk);
        cpu_rx_pop = 0; err_wr = 0;
        chk("R7 set wins", 32'(err_flags), 32'(exp_err));
        err_write(4'b0000);
        exp_err = 0;
        chk("R7 clear all", 32'(err_flags), 0);
        chk("R8 irq after clear", 32'(irq), 0);

        // R9 clear holds queue empty
        push_rx(val(1)); push_rx(val(2)); push_rx(val(3));
        chk("R9 rx before clr", 32'(rx_count), 3);
        @(negedge clk);
        rx_clr = 1;
        @(negedge clk);
        chk("R9 rx cleared", 32'(rx_count), 0);
        chk("R9 rx data zero", cpu_rx_data, 0);
        ser_rx_push = 1; ser_rx_data = val(9); cpu_rx_pop = 1;
        @(negedge clk);
        ser_rx_push = 0; cpu_rx_pop = 0;
        chk("R9 rx push ignored", 32'(rx_count), 0);
        chk("R9 no error", 32'(err_flags), 0);
        push_tx(val(4));
        @(negedge clk);
        tx_clr = 1; cpu_tx_push = 1; ser_tx_pop = 1;
        @(negedge clk);
        cpu_tx_push = 0; ser_tx_pop = 0;
        @(negedge clk);
        chk("R9 tx cleared", 32'(tx_count), 0);
        chk("R9 tx no error", 32'(err_flags), 0);
        rx_clr = 0; tx_clr = 0;

        // R10 byte swap on processor side only
        swap_en = 1;
        push_tx(32'h11223344);
        chk("R10 tx stored swapped", ser_tx_data, 32'h22114433);
        push_rx(32'hAABBCCDD);
        chk("R10 rx read swapped", cpu_rx_data, 32'hBBAADDCC);
        swap_en = 0;
        #0.5;
        chk("R10 rx raw", cpu_rx_data, 32'hAABBCCDD);
        chk("R10 tx unaffected", ser_tx_data, 32'h22114433);
        pop_tx(); pop_rx();
        chk("R2 both drained", 32'({tx_count, rx_count}), 0);

        finish_run();
    end
endmodule